// File: doc/BRIEF.md
# Invalidation queue error capture unit

This block watches a descriptor-based invalidation queue for faults and keeps a record of the first fault of each class. Pulses arrive from neighbouring logic: an invalid tail pointer, a failed descriptor fetch, an unknown descriptor type, a reserved-field violation, a failing completion message and a set of time-out monitors. The block also checks the programmed queue configuration on its own. A software write to the tail pointer or to the translation-mode register starts that check. The check covers the descriptor width against the translation mode and the scalable-mode capability, the tail alignment for wide descriptors, and the legality of the mode value.

There are three sticky flags: queue error, completion error and time-out error. Each flag has its own capture field in a 64-bit read-only info word. The first fault of a class sets the flag and loads the field. Later faults of that class are dropped until software clears the flag by writing 1 to it. A capture field is meaningful only while its flag is set.

Top module: `iq_err_capture`

## Requirements
- R1: The info word `err_info` holds the completion requester ID in bits 63:48, the time-out requester ID in bits 47:32 and the queue cause code in bits 3:0. Bits 31:4 always read as zero.
- R2: A `cmpl_err` pulse seen while `flag_cmpl` is clear sets `flag_cmpl` and loads `cmpl_rid` into bits 63:48. Both are visible in the next cycle.
- R3: While `flag_cmpl` is set, further `cmpl_err` pulses leave bits 63:48 unchanged.
- R4: Any bit of `tmo_err` seen while `flag_tmo` is clear sets `flag_tmo` and loads bits 47:32 in the next cycle. The ID recorded is slice `tmo_rid[16*i +: 16]` of the lowest set index i.
- R5: While `flag_tmo` is set, further time-outs leave bits 47:32 unchanged.
- R6: While `flag_qerr` is clear, a pulse sets `flag_qerr` in the next cycle and records its cause code. `tail_bad` records 1, `fetch_fault` records 2, `desc_type_bad` records 3 and `desc_rsvd_bad` records 4. While `flag_qerr` is set, the recorded code does not change.
- R7: Cause 5 (width illegal) is raised in two cases. The first is `cfg_wide`=0 with `cfg_mode`=2'b01. The second is `cfg_wide`=1 with `cap_scalable`=0. With `cfg_wide`=1, `cap_scalable`=1, `cfg_mode`=2'b01 and `tail_b4`=0, no cause is raised.
- R8: Cause 6 (misaligned tail) is raised when `cfg_wide`=1 and `tail_b4`=1.
- R9: Cause 7 (mode illegal) is raised when `cfg_mode` is 2'b10 or 2'b11.
- R10: The configuration values present in the cycle of a `cfg_write` pulse are checked one cycle later. The resulting flag is visible two cycles after the write. When several causes arise in one cycle, the lowest nonzero code is recorded.
- R11: With `clr_wr`=1, `clr_mask` bit 0 clears `flag_qerr`, bit 1 clears `flag_cmpl` and bit 2 clears `flag_tmo`, one cycle later. A fault that arrives in the same cycle as the clear of a set flag is dropped. A fault that arrives while the flag is already clear is captured. Clearing a flag leaves its field value unchanged.
- R12: A synchronous active-low reset clears all flags, the pending configuration check and every bit of `err_info`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_write | input | 1 | Software wrote the tail or mode register |
| cfg_wide | input | 1 | Descriptor width: 0 = 128-bit, 1 = 256-bit |
| cfg_mode | input | 2 | Translation mode: 00 legacy, 01 scalable, 10/11 illegal |
| cap_scalable | input | 1 | Scalable mode is supported |
| tail_b4 | input | 1 | Bit 4 of the queue tail pointer |
| tail_bad | input | 1 | Invalid tail pointer pulse |
| fetch_fault | input | 1 | Descriptor fetch failure pulse |
| desc_type_bad | input | 1 | Unknown descriptor type pulse |
| desc_rsvd_bad | input | 1 | Reserved-field violation pulse |
| cmpl_err | input | 1 | Completion error pulse |
| cmpl_rid | input | 16 | Requester ID of the failing completion |
| tmo_err | input | NUM_TMO | Time-out pulses, one per monitor |
| tmo_rid | input | 16*NUM_TMO | Requester IDs, monitor i in slice i |
| clr_wr | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 3 | Flags to clear: bit0 queue, bit1 completion, bit2 time-out |
| flag_qerr | output | 1 | Queue error flag |
| flag_cmpl | output | 1 | Completion error flag |
| flag_tmo | output | 1 | Time-out error flag |
| err_info | output | 64 | Captured info word |

## Verification
A fault pulse, a clear or a reset changes the outputs one clock edge later. A configuration write takes two edges, because it first lands in a snapshot register and is only then checked. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge, and the bench compares all outputs with the model at every falling edge. The directed checks sample at the falling edge one cycle after a pulse. For configuration writes, they sample both one and two cycles after the write, which confirms that the flag does not appear early.

// File: rtl/iqe_pkg.sv
package iqe_pkg;

    localparam int RID_W     = 16;
    localparam int INFO_W    = 64;
    localparam int CAUSE_W   = 4;
    localparam int NUM_CAUSE = 7;
    localparam int PAD_W     = INFO_W - 2 * RID_W - CAUSE_W;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_NONE      = 4'd0;
    localparam cause_t CAUSE_TAIL      = 4'd1;
    localparam cause_t CAUSE_FETCH     = 4'd2;
    localparam cause_t CAUSE_TYPE      = 4'd3;
    localparam cause_t CAUSE_RSVD      = 4'd4;
    localparam cause_t CAUSE_WIDTH     = 4'd5;
    localparam cause_t CAUSE_ALIGN     = 4'd6;
    localparam cause_t CAUSE_MODE      = 4'd7;

    localparam logic [1:0] MODE_LEGACY   = 2'b00;
    localparam logic [1:0] MODE_SCALABLE = 2'b01;

    // configuration snapshot taken on a software write
    typedef struct packed {
        logic       pend;
        logic       wide;
        logic [1:0] mode;
        logic       cap;
        logic       tb4;
    } cfg_snap_t;

    // sticky capture state
    typedef struct packed {
        logic             qerr;
        logic             cmpl;
        logic             tmo;
        cause_t           cause;
        logic [RID_W-1:0] cmpl_rid;
        logic [RID_W-1:0] tmo_rid;
    } cap_state_t;

endpackage

// File: rtl/iqe_prio_lowest.sv
module iqe_prio_lowest #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic below_hit;

    assign any = |req;

    // scan from the top so the lowest set request is written last
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        below_hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if ((i < int'(idx)) && req[i]) begin
                below_hit = 1'b1;
            end
        end
    end

    always_comb begin
        if (any) begin
            AST_PICK_IS_REQ: assert (req[idx]);       // R4
            AST_PICK_IS_LOWEST: assert (!below_hit);  // R10
        end
    end

endmodule

// File: rtl/iqe_cfg_check.sv
module iqe_cfg_check
    import iqe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_write,
    input  logic       cfg_wide,
    input  logic [1:0] cfg_mode,
    input  logic       cap_scalable,
    input  logic       tail_b4,
    output logic       fault_width,
    output logic       fault_align,
    output logic       fault_mode
);

    cfg_snap_t snap_d, snap_q;

    // R10: snapshot the configuration in the write cycle, check it next cycle
    always_comb begin
        snap_d      = snap_q;
        snap_d.pend = cfg_write;
        if (cfg_write) begin
            snap_d.wide = cfg_wide;
            snap_d.mode = cfg_mode;
            snap_d.cap  = cap_scalable;
            snap_d.tb4  = tail_b4;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    // R7: narrow descriptors in scalable mode, or wide without capability
    assign fault_width = snap_q.pend &
                         (((!snap_q.wide) && (snap_q.mode == MODE_SCALABLE)) ||
                          (snap_q.wide && !snap_q.cap));
    // R8: wide descriptors need a tail on a 32-byte boundary
    assign fault_align = snap_q.pend & snap_q.wide & snap_q.tb4;
    // R9: upper mode encodings are not defined
    assign fault_mode  = snap_q.pend & snap_q.mode[1];

    AST_FAULT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_width || fault_align || fault_mode) |-> $past(cfg_write)); // R10

endmodule

// File: rtl/iq_err_capture.sv
module iq_err_capture
    import iqe_pkg::*;
#(
    parameter int NUM_TMO = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_write,
    input  logic                     cfg_wide,
    input  logic [1:0]               cfg_mode,
    input  logic                     cap_scalable,
    input  logic                     tail_b4,
    input  logic                     tail_bad,
    input  logic                     fetch_fault,
    input  logic                     desc_type_bad,
    input  logic                     desc_rsvd_bad,
    input  logic                     cmpl_err,
    input  logic [RID_W-1:0]         cmpl_rid,
    input  logic [NUM_TMO-1:0]       tmo_err,
    input  logic [NUM_TMO*RID_W-1:0] tmo_rid,
    input  logic                     clr_wr,
    input  logic [2:0]               clr_mask,
    output logic                     flag_qerr,
    output logic                     flag_cmpl,
    output logic                     flag_tmo,
    output logic [INFO_W-1:0]        err_info
);

    localparam int TMO_IDX_W   = (NUM_TMO > 1) ? $clog2(NUM_TMO) : 1;
    localparam int CAUSE_IDX_W = $clog2(NUM_CAUSE);

    logic                   fault_width, fault_align, fault_mode;
    logic [NUM_CAUSE-1:0]   cause_req;
    logic                   cause_any;
    logic [CAUSE_IDX_W-1:0] cause_idx;
    logic                   tmo_any;
    logic [TMO_IDX_W-1:0]   tmo_idx;
    logic [RID_W-1:0]       tmo_rid_sel;
    logic                   clr_q, clr_c, clr_t;

    cap_state_t st_d, st_q;

    iqe_cfg_check u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_write    (cfg_write),
        .cfg_wide     (cfg_wide),
        .cfg_mode     (cfg_mode),
        .cap_scalable (cap_scalable),
        .tail_b4      (tail_b4),
        .fault_width  (fault_width),
        .fault_align  (fault_align),
        .fault_mode   (fault_mode)
    );

    // bit i of the request vector stands for cause code i+1 (R6..R9)
    assign cause_req = {fault_mode, fault_align, fault_width,
                        desc_rsvd_bad, desc_type_bad, fetch_fault, tail_bad};

    iqe_prio_lowest #(.N(NUM_CAUSE), .IDX_W(CAUSE_IDX_W)) u_cause_pick (
        .req (cause_req),
        .any (cause_any),
        .idx (cause_idx)
    );

    // R4: lowest-index monitor wins among simultaneous time-outs
    iqe_prio_lowest #(.N(NUM_TMO), .IDX_W(TMO_IDX_W)) u_tmo_pick (
        .req (tmo_err),
        .any (tmo_any),
        .idx (tmo_idx)
    );

    assign tmo_rid_sel = tmo_rid[tmo_idx*RID_W +: RID_W];

    assign clr_q = clr_wr & clr_mask[0];
    assign clr_c = clr_wr & clr_mask[1];
    assign clr_t = clr_wr & clr_mask[2];

    // R11: a set flag only listens to its clear; a clear flag captures
    always_comb begin
        st_d = st_q;

        if (st_q.qerr) begin
            if (clr_q) st_d.qerr = 1'b0;
        end else if (cause_any) begin
            st_d.qerr  = 1'b1;
            st_d.cause = CAUSE_W'(cause_idx) + CAUSE_W'(1);
        end

        if (st_q.cmpl) begin
            if (clr_c) st_d.cmpl = 1'b0;
        end else if (cmpl_err) begin
            st_d.cmpl     = 1'b1;
            st_d.cmpl_rid = cmpl_rid;
        end

        if (st_q.tmo) begin
            if (clr_t) st_d.tmo = 1'b0;
        end else if (tmo_any) begin
            st_d.tmo     = 1'b1;
            st_d.tmo_rid = tmo_rid_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;        // R12
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_qerr = st_q.qerr;
    assign flag_cmpl = st_q.cmpl;
    assign flag_tmo  = st_q.tmo;
    // R1: field layout of the info word
    assign err_info  = {st_q.cmpl_rid, st_q.tmo_rid, {PAD_W{1'b0}}, st_q.cause};

    AST_QERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_qerr |-> (err_info[3:0] != CAUSE_NONE)); // R6

    AST_QERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_qerr && !clr_q) |=> (flag_qerr && $stable(err_info[3:0]))); // R6

    AST_CMPL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_cmpl && cmpl_err) |=> (flag_cmpl && (err_info[63:48] == $past(cmpl_rid)))); // R2

    AST_CMPL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cmpl && !clr_c) |=> (flag_cmpl && $stable(err_info[63:48]))); // R3

    AST_TMO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_tmo && (|tmo_err)) |=> flag_tmo); // R4

    AST_TMO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_tmo && !clr_t) |=> (flag_tmo && $stable(err_info[47:32]))); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cmpl && clr_c) |=> !flag_cmpl); // R11

endmodule

// File: tb/iq_err_capture_bench.sv
`timescale 1ns/1ps
module iq_err_capture_bench;

    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_write = 0, cfg_wide = 0, cap_scalable = 0, tail_b4 = 0;
    logic [1:0]    cfg_mode = 0;
    logic          tail_bad = 0, fetch_fault = 0, desc_type_bad = 0, desc_rsvd_bad = 0;
    logic          cmpl_err = 0;
    logic [15:0]   cmpl_rid = 0;
    logic [NT-1:0] tmo_err = 0;
    logic [NT*16-1:0] tmo_rid = 0;
    logic          clr_wr = 0;
    logic [2:0]    clr_mask = 0;
    logic          flag_qerr, flag_cmpl, flag_tmo;
    logic [63:0]   err_info;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    iq_err_capture #(.NUM_TMO(NT)) u_iq_err_capture (
        .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_wide(cfg_wide),
        .cfg_mode(cfg_mode), .cap_scalable(cap_scalable), .tail_b4(tail_b4),
        .tail_bad(tail_bad), .fetch_fault(fetch_fault), .desc_type_bad(desc_type_bad),
        .desc_rsvd_bad(desc_rsvd_bad), .cmpl_err(cmpl_err), .cmpl_rid(cmpl_rid),
        .tmo_err(tmo_err), .tmo_rid(tmo_rid), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .flag_qerr(flag_qerr), .flag_cmpl(flag_cmpl), .flag_tmo(flag_tmo),
        .err_info(err_info)
    );

    // behavioural reference model
    logic        m_qf = 0, m_cf = 0, m_tf = 0;
    int          m_code = 0;
    logic [15:0] m_crid = 0, m_trid = 0;
    logic        m_pend = 0, m_wide = 0, m_cap = 0, m_tb4 = 0;
    logic [1:0]  m_mode = 0;
    int          code;
    int          win;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_qf <= 0; m_cf <= 0; m_tf <= 0; m_code <= 0;
            m_crid <= 0; m_trid <= 0; m_pend <= 0;
            m_wide <= 0; m_cap <= 0; m_tb4 <= 0; m_mode <= 0;
        end else begin
            code = 0;
            if (tail_bad) code = 1;
            else if (fetch_fault) code = 2;
            else if (desc_type_bad) code = 3;
            else if (desc_rsvd_bad) code = 4;
            else if (m_pend && ((!m_wide && m_mode == 2'b01) || (m_wide && !m_cap))) code = 5;
            else if (m_pend && m_wide && m_tb4) code = 6;
            else if (m_pend && m_mode >= 2) code = 7;
            if (m_qf) begin
                if (clr_wr && clr_mask[0]) m_qf <= 0;
            end else if (code != 0) begin
                m_qf <= 1; m_code <= code;
            end
            if (m_cf) begin
                if (clr_wr && clr_mask[1]) m_cf <= 0;
            end else if (cmpl_err) begin
                m_cf <= 1; m_crid <= cmpl_rid;
            end
            win = -1;
            for (int i = NT - 1; i >= 0; i--) if (tmo_err[i]) win = i;
            if (m_tf) begin
                if (clr_wr && clr_mask[2]) m_tf <= 0;
            end else if (win >= 0) begin
                m_tf <= 1; m_trid <= tmo_rid[win*16 +: 16];
            end
            m_pend <= cfg_write;
            if (cfg_write) begin
                m_wide <= cfg_wide; m_mode <= cfg_mode; m_cap <= cap_scalable; m_tb4 <= tail_b4;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk("R6 model qerr+cause", {flag_qerr, err_info[3:0]}, {m_qf, 4'(m_code)});
        chk("R2 model cmpl", {flag_cmpl, err_info[63:48]}, {m_cf, m_crid});
        chk("R4 model tmo", {flag_tmo, err_info[47:32]}, {m_tf, m_trid});
        chk("R1 model pad", 64'(err_info[31:4]), 64'd0);
    endtask

    task automatic idle();
        cfg_write = 0; tail_bad = 0; fetch_fault = 0; desc_type_bad = 0;
        desc_rsvd_bad = 0; cmpl_err = 0; tmo_err = 0; clr_wr = 0; clr_mask = 0;
    endtask

    task automatic clear(input logic [2:0] m);
        clr_wr = 1; clr_mask = m; cyc(); idle();
    endtask

    task automatic cfg_try(input logic w, input logic [1:0] md, input logic cp, input logic t4);
        cfg_wide = w; cfg_mode = md; cap_scalable = cp; tail_b4 = t4; cfg_write = 1;
        cyc(); idle();
        chk("R10 no flag one cycle after write", 64'(flag_qerr), 64'd0);
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog (all): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) cyc();
        chk("R12 flags after reset", 64'({flag_qerr, flag_cmpl, flag_tmo}), 64'd0);
        chk("R12 info after reset", err_info, 64'd0);
        rst_n = 1;
        cyc();

        cmpl_err = 1; cmpl_rid = 16'hBEEF; cyc(); idle();
        chk("R2 flag", 64'(flag_cmpl), 64'd1);
        chk("R2 rid", 64'(err_info[63:48]), 64'hBEEF);
        cmpl_err = 1; cmpl_rid = 16'h1234; cyc(); idle();
        chk("R3 rid held", 64'(err_info[63:48]), 64'hBEEF);
        clear(3'b010);
        chk("R11 cmpl cleared", 64'(flag_cmpl), 64'd0);
        chk("R11 field kept", 64'(err_info[63:48]), 64'hBEEF);

        tmo_rid = {16'h4444, 16'h2222, 16'h1111, 16'h0000};
        tmo_err = 4'b0110; cyc(); idle();
        chk("R4 flag", 64'(flag_tmo), 64'd1);
        chk("R4 lowest index rid", 64'(err_info[47:32]), 64'h1111);
        tmo_rid[15:0] = 16'h0AAA; tmo_err = 4'b0001; cyc(); idle();
        chk("R5 rid held", 64'(err_info[47:32]), 64'h1111);
        chk("R1 layout", err_info, {16'hBEEF, 16'h1111, 32'h0});

        tail_bad = 1; desc_rsvd_bad = 1; cyc(); idle();
        chk("R10 lowest cause", 64'(err_info[3:0]), 64'd1);
        fetch_fault = 1; cyc(); idle();
        chk("R6 held while set", 64'(err_info[3:0]), 64'd1);
        clear(3'b001);
        fetch_fault = 1; cyc(); idle();
        chk("R6 fetch code", 64'(err_info[3:0]), 64'd2);
        clear(3'b001);
        desc_type_bad = 1; cyc(); idle();
        chk("R6 type code", 64'(err_info[3:0]), 64'd3);
        clear(3'b001);
        desc_rsvd_bad = 1; cyc(); idle();
        chk("R6 reserved code", 64'(err_info[3:0]), 64'd4);
        clear(3'b001);

        cfg_try(1'b0, 2'b01, 1'b1, 1'b0);
        chk("R7 narrow in scalable", 64'({flag_qerr, err_info[3:0]}), 64'h15);
        clear(3'b001);
        cfg_try(1'b1, 2'b00, 1'b0, 1'b0);
        chk("R7 wide without capability", 64'({flag_qerr, err_info[3:0]}), 64'h15);
        clear(3'b001);
        cfg_try(1'b1, 2'b01, 1'b1, 1'b0);
        chk("R7 legal config", 64'(flag_qerr), 64'd0);
        cfg_try(1'b1, 2'b00, 1'b1, 1'b1);
        chk("R8 misaligned tail", 64'({flag_qerr, err_info[3:0]}), 64'h16);
        clear(3'b001);
        cfg_try(1'b0, 2'b10, 1'b1, 1'b0);
        chk("R9 mode 10", 64'({flag_qerr, err_info[3:0]}), 64'h17);
        clear(3'b001);
        cfg_try(1'b0, 2'b11, 1'b0, 1'b1);
        chk("R9 mode 11", 64'({flag_qerr, err_info[3:0]}), 64'h17);
        clear(3'b001);
        cfg_try(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R10 align beats mode", 64'({flag_qerr, err_info[3:0]}), 64'h16);

        clr_wr = 1; clr_mask = 3'b010; cmpl_err = 1; cmpl_rid = 16'h5555; cyc(); idle();
        chk("R11 clear flag captures", 64'({flag_cmpl, err_info[63:48]}), 64'h15555);
        clr_wr = 1; clr_mask = 3'b010; cmpl_err = 1; cmpl_rid = 16'h6666; cyc(); idle();
        chk("R11 clear wins on set flag", 64'({flag_cmpl, err_info[63:48]}), 64'h05555);

        rst_n = 0; cyc(); rst_n = 1;
        chk("R12 mid-run reset", 64'({flag_qerr, flag_cmpl, flag_tmo}), 64'd0);
        chk("R12 mid-run info", err_info, 64'd0);

        for (int k = 0; k < 600; k++) begin
            tail_bad      = ($urandom % 23) == 0;
            fetch_fault   = ($urandom % 23) == 0;
            desc_type_bad = ($urandom % 23) == 0;
            desc_rsvd_bad = ($urandom % 23) == 0;
            cmpl_err      = ($urandom % 7) == 0;
            cmpl_rid      = 16'($urandom);
            tmo_err       = (($urandom % 5) == 0) ? NT'($urandom) : '0;
            tmo_rid       = {$urandom, $urandom};
            cfg_write     = ($urandom % 9) == 0;
            cfg_wide      = 1'($urandom);
            cfg_mode      = 2'($urandom);
            cap_scalable  = 1'($urandom);
            tail_b4       = 1'($urandom);
            clr_wr        = ($urandom % 4) == 0;
            clr_mask      = 3'($urandom);
            cyc();
        end
        idle();
        cyc();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule